// File: doc/BRIEF.md
# Display Timing Generator

This block drives the horizontal sync, vertical sync and data-enable lines of a parallel RGB panel from a pair of pixel-clock counters. Each boundary of the line and of the frame is programmed as a cumulative count measured from the first sync pixel. The sync boundary holds the sync length minus one, and each later boundary (back porch, active, total) adds its own segment to the one before it. A line-position interrupt and the live X/Y position make it possible to pace frame updates.

Software writes the timing values through a simple write port into shadow registers. A reload register then moves the whole shadow set into the working set, either on the next clock or at the frame wrap, so that a timing change never tears a frame. A global enable and polarity controls apply at once and are not shadowed.

Top module: `disp_timing_gen`

## Requirements
- R1: Word addresses: 0 control, 1 sync, 2 back porch, 3 active, 4 total, 5 reload, 6 line position, 7 interrupt enable, 8 interrupt clear. Registers 1 to 4 hold the horizontal value in bits 27:16 and the vertical value in bits 10:0. Register 6 holds the line in bits 10:0. Writes to registers 1 to 4 and 6 land in shadow storage and do not change any output until a reload copies them.
- R2: Writing reload bit 0 copies the shadow set into the working set at the next clock edge, and bit 0 reads back as 0 on `reload_state` from that edge on.
- R3: Writing reload bit 1 copies the shadow set at the edge that ends the last pixel of the last line, where the counters wrap from their totals to 0. While the generator is disabled it copies at the next edge. Bit 1 clears when the copy is made.
- R4: While enabled, `pos_x` counts from 0 up to the horizontal total and then returns to 0, stepping `pos_y`. `pos_y` returns to 0 after the line whose number equals the vertical total. A counter at or above its total wraps.
- R5: Horizontal sync is active while `pos_x` is at or below the horizontal sync field, and vertical sync while `pos_y` is at or below the vertical sync field. Control bit 31 (horizontal) and bit 30 (vertical) set 1 = active-high and 0 = active-low.
- R6: Data-enable is active while `pos_x` lies above the horizontal back-porch sum and at or below the horizontal active sum, and `pos_y` meets the same rule on the vertical values. Control bit 29 sets its polarity as in R5.
- R7: Control bit 0 enables the generator. While it is 0 both counters are held at 0 and the three timing outputs are at their inactive level.
- R8: The interrupt status sets at the edge that leaves a cycle where the generator is enabled, `pos_x` is 0 and `pos_y` equals the working line position. It stays set until bit 0 of the clear register is written with 1. If the set and the clear fall in the same cycle, the set wins.
- R9: `line_irq` is the interrupt status AND bit 0 of the interrupt enable register.
- R10: `pclk_inv` follows control bit 28 from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk_inv | output | 1 | Pixel clock edge inversion request |
| pos_x | output | 12 | Current horizontal counter |
| pos_y | output | 11 | Current vertical counter |
| line_irq | output | 1 | Line-position interrupt |
| reload_state | output | 2 | Pending reload bits |

## Verification
Two events can fall in the same cycle. A clear write can arrive in the very cycle the line-position match sets the status. A blanking reload can be pending while the counters wrap, and a new reload write can land on the same edge. The bench predicts the cycle of each line match and, in about half of those cycles, drives the clear there. It then expects the status to stay set and checks that such a collision happened at least once. Reload timing is compared every cycle against a reference model of the shadow and working sets, through the sync, data-enable and position outputs.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  parameter int unsigned HCW = 12;
  parameter int unsigned VCW = 11;
  parameter int unsigned ADW = 4;
  parameter int unsigned DW  = 32;
  localparam int unsigned HLSB = 16;

  typedef enum logic [ADW-1:0] {
    A_CTRL   = 4'd0,
    A_SYNC   = 4'd1,
    A_BPORCH = 4'd2,
    A_ACTIVE = 4'd3,
    A_TOTAL  = 4'd4,
    A_RELOAD = 4'd5,
    A_LINE   = 4'd6,
    A_IEN    = 4'd7,
    A_ICLR   = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic [HCW-1:0] sync_h;
    logic [HCW-1:0] bp_h;
    logic [HCW-1:0] act_h;
    logic [HCW-1:0] tot_h;
    logic [VCW-1:0] sync_v;
    logic [VCW-1:0] bp_v;
    logic [VCW-1:0] act_v;
    logic [VCW-1:0] tot_v;
    logic [VCW-1:0] line_v;
  } tcfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [ADW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           frame_end,
  output tcfg_t          act_cfg,
  output logic           run_en,
  output logic           pol_h,
  output logic           pol_v,
  output logic           pol_de,
  output logic           pol_clk,
  output logic           irq_en,
  output logic           irq_clr,
  output logic [1:0]     rl_state
);
  tcfg_t      shd;
  logic [1:0] rl;
  logic       copy;
  logic       wr_rl;

  assign wr_rl    = wr_en && (wr_addr == A_RELOAD);
  assign copy     = rl[0] | (rl[1] & (frame_end | ~run_en));
  assign irq_clr  = wr_en && (wr_addr == A_ICLR) && wr_data[0];
  assign rl_state = rl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd     <= '0;
      act_cfg <= '0;
      rl      <= 2'b00;
      run_en  <= 1'b0;
      pol_h   <= 1'b0;
      pol_v   <= 1'b0;
      pol_de  <= 1'b0;
      pol_clk <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_SYNC) begin
        shd.sync_h <= wr_data[HLSB +: HCW];
        shd.sync_v <= wr_data[VCW-1:0];
      end
      if (wr_en && wr_addr == A_BPORCH) begin
        shd.bp_h <= wr_data[HLSB +: HCW];
        shd.bp_v <= wr_data[VCW-1:0];
      end
      if (wr_en && wr_addr == A_ACTIVE) begin
        shd.act_h <= wr_data[HLSB +: HCW];
        shd.act_v <= wr_data[VCW-1:0];
      end
      if (wr_en && wr_addr == A_TOTAL) begin
        shd.tot_h <= wr_data[HLSB +: HCW];
        shd.tot_v <= wr_data[VCW-1:0];
      end
      if (wr_en && wr_addr == A_LINE)
        shd.line_v <= wr_data[VCW-1:0];
      if (wr_en && wr_addr == A_CTRL) begin
        run_en  <= wr_data[0];
        pol_clk <= wr_data[28];
        pol_de  <= wr_data[29];
        pol_v   <= wr_data[30];
        pol_h   <= wr_data[31];
      end
      if (wr_en && wr_addr == A_IEN)
        irq_en <= wr_data[0];
      if (copy)
        act_cfg <= shd;
      rl <= (copy ? 2'b00 : rl) | (wr_rl ? wr_data[1:0] : 2'b00);
    end
  end

  AST_IMM_SELFCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rl[0] && !wr_rl) |=> !rl[0]); // R2
  AST_BLANK_SELFCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rl[1] && frame_end && !wr_rl) |=> !rl[1]); // R3
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic [HCW-1:0] tot_h,
  input  logic [VCW-1:0] tot_v,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           frame_end
);
  logic line_end;

  assign line_end  = hcnt >= tot_h;
  assign frame_end = run_en && line_end && (vcnt >= tot_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run_en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= (vcnt >= tot_v) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && hcnt >= tot_h) |=> (hcnt == '0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (hcnt == '0 && vcnt == '0)); // R7
endmodule

// File: rtl/dtg_outputs.sv
module dtg_outputs
  import dtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  tcfg_t          cfg,
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  input  logic           run_en,
  input  logic           pol_h,
  input  logic           pol_v,
  input  logic           pol_de,
  input  logic           irq_en,
  input  logic           irq_clr,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic           line_irq
);
  localparam int unsigned NSIG = 3;
  logic [NSIG-1:0] act_lvl, pol_sel, out_lvl;
  logic            line_hit;
  logic            irq_st;

  assign act_lvl[0] = run_en && (hcnt <= cfg.sync_h);
  assign act_lvl[1] = run_en && (vcnt <= cfg.sync_v);
  assign act_lvl[2] = run_en && (hcnt > cfg.bp_h) && (hcnt <= cfg.act_h)
                             && (vcnt > cfg.bp_v) && (vcnt <= cfg.act_v);
  assign pol_sel    = {pol_de, pol_v, pol_h};

  for (genvar i = 0; i < NSIG; i++) begin : g_pol
    assign out_lvl[i] = pol_sel[i] ? act_lvl[i] : ~act_lvl[i];
  end

  assign hsync = out_lvl[0];
  assign vsync = out_lvl[1];
  assign de    = out_lvl[2];

  assign line_hit = run_en && (hcnt == '0) && (vcnt == cfg.line_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_st <= 1'b0;
    else        irq_st <= line_hit | (irq_st & ~irq_clr);
  end

  assign line_irq = irq_st & irq_en;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_st && !irq_clr) |=> irq_st); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hit && irq_clr) |=> irq_st); // R8
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [ADW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic           pclk_inv,
  output logic [HCW-1:0] pos_x,
  output logic [VCW-1:0] pos_y,
  output logic           line_irq,
  output logic [1:0]     reload_state
);
  tcfg_t          act_cfg;
  logic           run_en, pol_h, pol_v, pol_de, pol_clk;
  logic           irq_en, irq_clr, frame_end;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;

  dtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .frame_end(frame_end), .act_cfg(act_cfg),
    .run_en(run_en), .pol_h(pol_h), .pol_v(pol_v), .pol_de(pol_de),
    .pol_clk(pol_clk), .irq_en(irq_en), .irq_clr(irq_clr),
    .rl_state(reload_state)
  );

  dtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tot_h(act_cfg.tot_h),
    .tot_v(act_cfg.tot_v), .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end)
  );

  dtg_outputs u_out (
    .clk(clk), .rst_n(rst_n), .cfg(act_cfg), .hcnt(hcnt), .vcnt(vcnt),
    .run_en(run_en), .pol_h(pol_h), .pol_v(pol_v), .pol_de(pol_de),
    .irq_en(irq_en), .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync),
    .de(de), .line_irq(line_irq)
  );

  assign pclk_inv = pol_clk;
  assign pos_x    = hcnt;
  assign pos_y    = vcnt;
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
  import dtg_pkg::*;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [ADW-1:0] cfg_addr = '0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic           hsync, vsync, de, pclk_inv, line_irq;
  logic [HCW-1:0] pos_x;
  logic [VCW-1:0] pos_y;
  logic [1:0]     reload_state;

  int checks = 0, failures = 0, collisions = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .pclk_inv(pclk_inv), .pos_x(pos_x), .pos_y(pos_y),
    .line_irq(line_irq), .reload_state(reload_state)
  );

  // reference model state
  tcfg_t m_shd, m_act;
  bit m_en, m_ph, m_pv, m_pde, m_pclk, m_ien, m_st;
  bit [1:0] m_rl;
  int m_h, m_v;
  tcfg_t nc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit lvl(input bit pol, input bit a);
    return pol ? a : !a;
  endfunction

  task automatic check_all();
    bit hs, vs, d;
    string t;
    hs = lvl(m_ph, m_en && m_h <= int'(m_act.sync_h));
    vs = lvl(m_pv, m_en && m_v <= int'(m_act.sync_v));
    d  = lvl(m_pde, m_en && m_h > int'(m_act.bp_h) && m_h <= int'(m_act.act_h)
                    && m_v > int'(m_act.bp_v) && m_v <= int'(m_act.act_v));
    t = m_en ? "R5" : "R7";
    chk(hsync == hs, t, "hsync", hsync, hs);
    chk(vsync == vs, t, "vsync", vsync, vs);
    chk(de == d, m_en ? "R6" : "R7", "de", de, d);
    chk(pclk_inv == m_pclk, "R10", "pclk_inv", pclk_inv, m_pclk);
    chk(int'(pos_x) == m_h, "R4", "pos_x", pos_x, m_h);
    chk(int'(pos_y) == m_v, "R4", "pos_y", pos_y, m_v);
    chk(line_irq == (m_st && m_ien), "R8,R9", "line_irq", line_irq, m_st && m_ien);
    chk(reload_state == m_rl, "R2,R3", "reload_state", reload_state, m_rl);
  endtask

  task automatic model_step(input bit we, input logic [3:0] wa, input logic [31:0] wd);
    bit fe, cp, st_set, clr;
    tcfg_t n_shd;
    fe = m_en && m_h >= int'(m_act.tot_h) && m_v >= int'(m_act.tot_v);
    cp = m_rl[0] || (m_rl[1] && (fe || !m_en));
    st_set = m_en && m_h == 0 && m_v == int'(m_act.line_v);
    clr = we && wa == 4'd8 && wd[0];
    n_shd = m_shd;
    if (we) begin
      case (wa)
        4'd1: begin n_shd.sync_h = wd[27:16]; n_shd.sync_v = wd[10:0]; end
        4'd2: begin n_shd.bp_h = wd[27:16]; n_shd.bp_v = wd[10:0]; end
        4'd3: begin n_shd.act_h = wd[27:16]; n_shd.act_v = wd[10:0]; end
        4'd4: begin n_shd.tot_h = wd[27:16]; n_shd.tot_v = wd[10:0]; end
        4'd6: n_shd.line_v = wd[10:0];
        default: ;
      endcase
    end
    if (!m_en) begin m_h = 0; m_v = 0; end
    else if (m_h >= int'(m_act.tot_h)) begin
      m_h = 0;
      m_v = (m_v >= int'(m_act.tot_v)) ? 0 : m_v + 1;
    end else m_h = m_h + 1;
    m_st = st_set || (m_st && !clr);
    if (cp) m_act = m_shd;
    m_rl = (cp ? 2'b00 : m_rl) | ((we && wa == 4'd5) ? wd[1:0] : 2'b00);
    m_shd = n_shd;
    if (we && wa == 4'd0) begin
      m_en = wd[0]; m_pclk = wd[28]; m_pde = wd[29]; m_pv = wd[30]; m_ph = wd[31];
    end
    if (we && wa == 4'd7) m_ien = wd[0];
  endtask

  // one cycle: check, drive, advance model, wait to next negedge
  task automatic cyc(input bit we, input logic [3:0] wa, input logic [31:0] wd);
    check_all();
    cfg_wr = we; cfg_addr = wa; cfg_wdata = wd;
    model_step(we, wa, wd);
    @(negedge clk);
  endtask

  function automatic tcfg_t rand_cfg();
    tcfg_t c;
    c.sync_h = 12'($urandom % 3);
    c.bp_h   = c.sync_h + 12'(1 + $urandom % 3);
    c.act_h  = c.bp_h + 12'(1 + $urandom % 6);
    c.tot_h  = c.act_h + 12'(1 + $urandom % 3);
    c.sync_v = 11'($urandom % 2);
    c.bp_v   = c.sync_v + 11'(1 + $urandom % 2);
    c.act_v  = c.bp_v + 11'(1 + $urandom % 4);
    c.tot_v  = c.act_v + 11'(1 + $urandom % 2);
    c.line_v = ($urandom % 2 == 0) ? c.act_v + 11'd1 : 11'($urandom % (32'(c.tot_v) + 1));
    return c;
  endfunction

  function automatic logic [31:0] pair(input logic [11:0] h, input logic [10:0] v);
    return {4'h0, h, 5'h00, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit we;
    logic [3:0] wa;
    logic [31:0] wd;
    void'($urandom(32'd20240611));
    m_shd = '0; m_act = '0; m_rl = 2'b00; m_h = 0; m_v = 0;
    m_en = 0; m_ph = 0; m_pv = 0; m_pde = 0; m_pclk = 0; m_ien = 0; m_st = 0;
    @(negedge clk);
    // reset state (R7): inactive levels, counters zero
    repeat (3) begin check_all(); @(negedge clk); end
    rst_n = 1'b1;
    // directed: enable, then shadow write without reload (R1)
    cyc(1, 4'd0, 32'h0000_0001);
    cyc(1, 4'd4, pair(12'd9, 11'd5));
    cyc(0, 4'd0, 32'd0);
    cyc(0, 4'd0, 32'd0);
    chk(pos_x == 0 && pos_y == 0, "R1", "pos_x after unreloaded write", pos_x, 0);
    cyc(1, 4'd1, pair(12'd1, 11'd0));
    cyc(1, 4'd2, pair(12'd2, 11'd1));
    cyc(1, 4'd3, pair(12'd7, 11'd4));
    cyc(1, 4'd6, 32'd5);
    cyc(1, 4'd7, 32'd1);
    cyc(1, 4'd5, 32'd1); // immediate reload (R2)
    repeat (80) cyc(0, 4'd0, 32'd0);
    // polarity all high plus blanking reload (R3, R5, R10)
    cyc(1, 4'd0, 32'hF000_0001);
    cyc(1, 4'd4, pair(12'd11, 11'd6));
    cyc(1, 4'd5, 32'd2);
    repeat (200) cyc(0, 4'd0, 32'd0);
    // disabled: blanking reload copies at once (R3, R7)
    cyc(1, 4'd0, 32'h5000_0000);
    cyc(1, 4'd5, 32'd2);
    repeat (5) cyc(0, 4'd0, 32'd0);
    cyc(1, 4'd0, 32'h0000_0001);
    nc = rand_cfg();
    for (int n = 0; n < 6000; n++) begin
      int r;
      bit hit;
      hit = m_en && m_h == 0 && m_v == int'(m_act.line_v);
      r = $urandom % 100;
      we = 1; wa = 4'd0; wd = 32'd0;
      if (hit && m_st && ($urandom % 2 == 0)) begin
        wa = 4'd8; wd = 32'd1; collisions++;
      end else if (r < 55) we = 0;
      else if (r < 60) nc = rand_cfg();
      else if (r < 64) begin wa = 4'd1; wd = pair(nc.sync_h, nc.sync_v); end
      else if (r < 68) begin wa = 4'd2; wd = pair(nc.bp_h, nc.bp_v); end
      else if (r < 72) begin wa = 4'd3; wd = pair(nc.act_h, nc.act_v); end
      else if (r < 76) begin wa = 4'd4; wd = pair(nc.tot_h, nc.tot_v); end
      else if (r < 78) begin wa = 4'd6; wd = {21'd0, nc.line_v}; end
      else if (r < 83) begin wa = 4'd5; wd = {30'd0, 2'($urandom % 4)}; end
      else if (r < 90) begin wa = 4'd8; wd = 32'($urandom % 2); end
      else if (r < 94) begin wa = 4'd7; wd = 32'($urandom % 2); end
      else begin
        wa = 4'd0;
        wd = {4'($urandom), 27'd0, ($urandom % 8 != 0)};
      end
      if (we && wa == 4'd8) m_st = m_st; // clear handled in model
      cyc(we, wa, wd);
    end
    cyc(0, 4'd0, 32'd0);
    chk(collisions > 0, "R8", "set/clear collisions seen", collisions, 1);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule